// File: doc/BRIEF.md
# Current-Aware PWM Offset Selector

This block sits in front of the carrier comparators of a three-phase, five-level carrier PWM modulator. Every cycle it takes three sinusoidal references and three signed phase-current samples. It returns three modified references that all carry one shared zero-sequence offset. Because the offset is common to all phases, the line-to-line voltages do not change. What changes is which phase stops crossing carriers during the current carrier period. The offset is chosen so that the phase carrying the largest current, or failing that the medium current, is pushed exactly onto an edge of its carrier band and does not switch.

The reference range spans four stacked unit carriers, from 0.0 to 4.0, in unsigned Q3.13. For each phase the block finds the carrier band and the fractional position inside that band. It ranks the current magnitudes and the fractions with one-hot max/medium/min flags. It cross-ranks the two sets to pick one of four cases, then adds the offset with saturation. The result is registered, with a one-cycle valid.

Top module: `pwm_offset_sel`

## Requirements
- R1: A reference input above 4.0 (0x8000) is treated as exactly 4.0 before any other processing.
- R2: The band index of a reference is its integer part when that is below 4, and 3 for a reference of exactly 4.0. Its fraction (reference minus band) therefore lies in [0, 1.0].
- R3: Current magnitudes are ranked by absolute value, and -32768 ranks as 32768. On a tie for largest, the winner is phase a, then b, then c. On a tie for smallest, the winner is phase c, then b, then a. The medium phase is the one that is neither.
- R4: Fractions are ranked with the same tie rules as R3.
- R5: If the largest-current phase holds the largest fraction, the offset is 1.0 minus that fraction and case_code is 0.
- R6: If the largest-current phase holds the smallest fraction, the offset is minus that fraction and case_code is 1. Bit 0 of case_code set means the offset is zero or negative.
- R7: Otherwise the medium-current phase decides. If it holds the largest fraction, the offset is 1.0 minus the largest fraction and case_code is 2. If it holds the smallest fraction, the offset is minus the smallest fraction and case_code is 3.
- R8: Each modified reference equals its R1-clamped reference plus the offset, saturated to [0, 4.0]. The phase picked by R5 to R7 lands exactly on an integer.
- R9: The outputs of a sample with in_valid high appear after the next rising clock edge, with out_valid high. While in_valid is low, out_valid falls and mod_a, mod_b, mod_c and case_code hold their values.
- R10: During reset out_valid, mod_a, mod_b, mod_c and case_code are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe for the references and currents |
| ref_a | input | 16 | Phase a reference, unsigned Q3.13 |
| ref_b | input | 16 | Phase b reference, unsigned Q3.13 |
| ref_c | input | 16 | Phase c reference, unsigned Q3.13 |
| cur_a | input | 16 | Phase a current, signed |
| cur_b | input | 16 | Phase b current, signed |
| cur_c | input | 16 | Phase c current, signed |
| out_valid | output | 1 | Outputs hold a new result |
| mod_a | output | 16 | Phase a modified reference, Q3.13 |
| mod_b | output | 16 | Phase b modified reference, Q3.13 |
| mod_c | output | 16 | Phase c modified reference, Q3.13 |
| case_code | output | 2 | Selected offset case (R5 to R7) |

## Verification
Band splitting, ranking and offset choice are all combinational. The modified references and case_code for a sample therefore become visible after exactly one rising edge, together with out_valid. The bench drives each sample on a falling edge and compares against its own model on the next falling edge, after that single register stage has updated. It then drops in_valid, changes the inputs, and checks one falling edge later that the outputs did not move. The stimulus is a phase-angle sweep at modulation indices 0.1 to 1.0, plus random samples and directed ties, over-range inputs and band-edge inputs.

// File: rtl/pwm_offset_pkg.sv
package pwm_offset_pkg;

    // number of stacked unit carriers spanned by the reference
    localparam int NBANDS = 4;

    // bit 0 set: offset pulls downward
    typedef enum logic [1:0] {
        SEL_IMAX_UP = 2'd0,
        SEL_IMAX_DN = 2'd1,
        SEL_IMED_UP = 2'd2,
        SEL_IMED_DN = 2'd3
    } sel_case_e;

endpackage

// File: rtl/pwm_band_split.sv
module pwm_band_split #(
    parameter int REF_W  = 16,
    parameter int FRAC_W = 13,
    parameter int NBANDS = 4
) (
    input  logic [REF_W-1:0]  ref_i,
    output logic [REF_W-1:0]  ref_sat,
    output logic [FRAC_W:0]   frac
);
    localparam int INT_W = REF_W - FRAC_W;
    localparam logic [REF_W-1:0] TOP = REF_W'(NBANDS) << FRAC_W;

    logic [INT_W-1:0] ipart;
    logic [INT_W-1:0] band;
    logic [REF_W-1:0] base;

    always_comb begin
        // R1: clamp the reference to the top of the carrier stack
        ref_sat = (ref_i > TOP) ? TOP : ref_i;
        ipart   = ref_sat[REF_W-1:FRAC_W];
        // R2: exactly the top value belongs to the highest band
        band    = (ipart < INT_W'(NBANDS)) ? ipart : ipart - INT_W'(1);
        base    = {band, {FRAC_W{1'b0}}};
        frac    = (FRAC_W+1)'(ref_sat - base);
    end

endmodule

// File: rtl/pwm_rank3.sv
module pwm_rank3 #(
    parameter int W = 17
) (
    input  logic [W-1:0] v0,
    input  logic [W-1:0] v1,
    input  logic [W-1:0] v2,
    output logic [2:0]   max_oh,
    output logic [2:0]   min_oh,
    output logic [2:0]   med_oh
);
    always_comb begin
        // largest: ties go to index 0, then 1
        max_oh[0] = (v0 >= v1) && (v0 >= v2);
        max_oh[1] = !max_oh[0] && (v1 >= v2);
        max_oh[2] = !max_oh[0] && !max_oh[1];
        // smallest: ties go to index 2, then 1
        min_oh[2] = (v2 <= v0) && (v2 <= v1);
        min_oh[1] = !min_oh[2] && (v1 <= v0);
        min_oh[0] = !min_oh[2] && !min_oh[1];
        med_oh    = ~(max_oh | min_oh);
    end

endmodule

// File: rtl/pwm_offset_pick.sv
module pwm_offset_pick
    import pwm_offset_pkg::*;
#(
    parameter int FRAC_W = 13
) (
    input  logic [2:0][FRAC_W:0]   fracs,
    input  logic [2:0]             cmax_oh,
    input  logic [2:0]             cmed_oh,
    input  logic [2:0]             fmax_oh,
    input  logic [2:0]             fmin_oh,
    output logic signed [FRAC_W+1:0] offset,
    output sel_case_e              sel
);
    localparam logic [FRAC_W+1:0] ONE = (FRAC_W+2)'(1) << FRAC_W;

    logic [FRAC_W:0] fmax_val;
    logic [FRAC_W:0] fmin_val;
    logic signed [FRAC_W+1:0] up_off;
    logic signed [FRAC_W+1:0] dn_off;

    always_comb begin
        fmax_val = '0;
        fmin_val = '0;
        for (int i = 0; i < 3; i++) begin
            fmax_val = fmax_val | (fracs[i] & {(FRAC_W+1){fmax_oh[i]}});
            fmin_val = fmin_val | (fracs[i] & {(FRAC_W+1){fmin_oh[i]}});
        end
        up_off = $signed(ONE - {1'b0, fmax_val});
        dn_off = $signed((FRAC_W+2)'(0) - {1'b0, fmin_val});

        if (|(cmax_oh & fmax_oh)) begin
            sel    = SEL_IMAX_UP;
            offset = up_off;
        end else if (|(cmax_oh & fmin_oh)) begin
            sel    = SEL_IMAX_DN;
            offset = dn_off;
        end else if (|(cmed_oh & fmax_oh)) begin
            sel    = SEL_IMED_UP;
            offset = up_off;
        end else begin
            sel    = SEL_IMED_DN;
            offset = dn_off;
        end
    end

endmodule

// File: rtl/pwm_offset_sel.sv
module pwm_offset_sel
    import pwm_offset_pkg::*;
#(
    parameter int REF_W  = 16,
    parameter int FRAC_W = 13,
    parameter int CUR_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [REF_W-1:0]        ref_a,
    input  logic [REF_W-1:0]        ref_b,
    input  logic [REF_W-1:0]        ref_c,
    input  logic signed [CUR_W-1:0] cur_a,
    input  logic signed [CUR_W-1:0] cur_b,
    input  logic signed [CUR_W-1:0] cur_c,
    output logic                    out_valid,
    output logic [REF_W-1:0]        mod_a,
    output logic [REF_W-1:0]        mod_b,
    output logic [REF_W-1:0]        mod_c,
    output logic [1:0]              case_code
);
    localparam int MAG_W = CUR_W + 1;
    localparam int SUM_W = REF_W + 2;
    localparam logic [REF_W-1:0] TOP = REF_W'(NBANDS) << FRAC_W;

    typedef struct packed {
        logic                   valid;
        logic [2:0][REF_W-1:0]  mods;
        sel_case_e              sel;
    } out_t;

    logic [2:0][REF_W-1:0] ref_in;
    logic [2:0][REF_W-1:0] ref_sat;
    logic [2:0][FRAC_W:0]  fracs;
    logic [2:0][CUR_W-1:0] cur_in;
    logic [2:0][MAG_W-1:0] mags;
    logic [2:0] cmax_oh, cmin_oh, cmed_oh;
    logic [2:0] fmax_oh, fmin_oh, fmed_oh;
    logic signed [FRAC_W+1:0] offset;
    sel_case_e sel;
    logic signed [SUM_W-1:0] sums [3];
    out_t state_d, state_q;

    assign ref_in = {ref_c, ref_b, ref_a};
    assign cur_in = {cur_c, cur_b, cur_a};

    for (genvar g = 0; g < 3; g++) begin : g_phase
        pwm_band_split #(
            .REF_W (REF_W),
            .FRAC_W(FRAC_W),
            .NBANDS(NBANDS)
        ) u_band (
            .ref_i  (ref_in[g]),
            .ref_sat(ref_sat[g]),
            .frac   (fracs[g])
        );
        // R3: magnitude, with the most negative code mapping to its true size
        assign mags[g] = cur_in[g][CUR_W-1]
                       ? MAG_W'(0) - {cur_in[g][CUR_W-1], cur_in[g]}
                       : {1'b0, cur_in[g]};
    end

    pwm_rank3 #(.W(MAG_W)) u_rank_cur (
        .v0    (mags[0]),
        .v1    (mags[1]),
        .v2    (mags[2]),
        .max_oh(cmax_oh),
        .min_oh(cmin_oh),
        .med_oh(cmed_oh)
    );

    pwm_rank3 #(.W(FRAC_W+1)) u_rank_frac (
        .v0    (fracs[0]),
        .v1    (fracs[1]),
        .v2    (fracs[2]),
        .max_oh(fmax_oh),
        .min_oh(fmin_oh),
        .med_oh(fmed_oh)
    );

    pwm_offset_pick #(.FRAC_W(FRAC_W)) u_pick (
        .fracs  (fracs),
        .cmax_oh(cmax_oh),
        .cmed_oh(cmed_oh),
        .fmax_oh(fmax_oh),
        .fmin_oh(fmin_oh),
        .offset (offset),
        .sel    (sel)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        for (int i = 0; i < 3; i++) begin
            sums[i] = $signed({2'b00, ref_sat[i]}) + SUM_W'(offset);
        end
        if (in_valid) begin
            state_d.sel = sel;
            for (int i = 0; i < 3; i++) begin
                if (sums[i] < 0) begin
                    state_d.mods[i] = '0;
                end else if (sums[i] > $signed({2'b00, TOP})) begin
                    state_d.mods[i] = TOP;
                end else begin
                    state_d.mods[i] = sums[i][REF_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign mod_a     = state_q.mods[0];
    assign mod_b     = state_q.mods[1];
    assign mod_c     = state_q.mods[2];
    assign case_code = state_q.sel;

endmodule

// File: rtl/pwm_offset_sel_chk.sv
module pwm_offset_sel_chk #(
    parameter int REF_W  = 16,
    parameter int FRAC_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [REF_W-1:0] ref_a,
    input logic [REF_W-1:0] ref_b,
    input logic [REF_W-1:0] ref_c,
    input logic             out_valid,
    input logic [REF_W-1:0] mod_a,
    input logic [REF_W-1:0] mod_b,
    input logic [REF_W-1:0] mod_c,
    input logic [1:0]       case_code
);
    localparam logic [REF_W-1:0] TOP = REF_W'(4) << FRAC_W;

    function automatic logic [REF_W-1:0] clampv(input logic [REF_W-1:0] v);
        return (v > TOP) ? TOP : v;
    endfunction

    function automatic logic signed [REF_W:0] dif(input logic [REF_W-1:0] m,
                                                  input logic [REF_W-1:0] r);
        return $signed({1'b0, m}) - $signed({1'b0, r});
    endfunction

    function automatic logic inside_open(input logic [REF_W-1:0] m);
        return (m != '0) && (m != TOP);
    endfunction

    // R9: valid follows the sample strobe by one edge
    assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    // R9: outputs hold while no sample is taken
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(mod_a) && $stable(mod_b) && $stable(mod_c) && $stable(case_code)));

    // R8: outputs stay inside the carrier stack
    assert_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mod_a <= TOP && mod_b <= TOP && mod_c <= TOP));

    // R8: the selected phase lands on a carrier edge
    assert_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mod_a[FRAC_W-1:0] == '0 || mod_b[FRAC_W-1:0] == '0
                       || mod_c[FRAC_W-1:0] == '0));

    // R8: a common shift when nothing saturated
    assert_common_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(ref_a) <= TOP && $past(ref_b) <= TOP && $past(ref_c) <= TOP
         && inside_open(mod_a) && inside_open(mod_b) && inside_open(mod_c))
        |-> (dif(mod_a, $past(ref_a)) == dif(mod_b, $past(ref_b))
             && dif(mod_b, $past(ref_b)) == dif(mod_c, $past(ref_c))));

    // R6: bit 0 of the case code gives the shift direction
    assert_direction_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (case_code[0] ? (mod_a <= clampv($past(ref_a)))
                                    : (mod_a >= clampv($past(ref_a)))));

endmodule

bind pwm_offset_sel pwm_offset_sel_chk #(
    .REF_W (REF_W),
    .FRAC_W(FRAC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .ref_a    (ref_a),
    .ref_b    (ref_b),
    .ref_c    (ref_c),
    .out_valid(out_valid),
    .mod_a    (mod_a),
    .mod_b    (mod_b),
    .mod_c    (mod_c),
    .case_code(case_code)
);

// File: tb/sim_pwm_offset_sel.sv
module sim_pwm_offset_sel;
    localparam int ONE = 8192;
    localparam int TOP = 4 * ONE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [15:0] ref_a = '0, ref_b = '0, ref_c = '0;
    logic signed [15:0] cur_a = '0, cur_b = '0, cur_c = '0;
    logic out_valid;
    logic [15:0] mod_a, mod_b, mod_c;
    logic [1:0] case_code;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    int tr [3];
    int tc [3];
    int exp_mod [3];
    int exp_case;

    always #5 clk = ~clk;

    pwm_offset_sel u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
        .cur_a(cur_a), .cur_b(cur_b), .cur_c(cur_c),
        .out_valid(out_valid), .mod_a(mod_a), .mod_b(mod_b), .mod_c(mod_c),
        .case_code(case_code)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // reference model written from the requirements
    task automatic model();
        int rc [3];
        int fr [3];
        int mg [3];
        int imax, imin, imed, fmaxi, fmini, off, ip, bnd;
        for (int k = 0; k < 3; k++) begin
            rc[k] = (tr[k] > TOP) ? TOP : tr[k];               // R1
            ip = rc[k] / ONE;
            bnd = (ip < 4) ? ip : ip - 1;                       // R2
            fr[k] = rc[k] - bnd * ONE;
            mg[k] = (tc[k] < 0) ? -tc[k] : tc[k];               // R3
        end
        imax = 0;
        for (int k = 1; k < 3; k++) if (mg[k] > mg[imax]) imax = k;
        imin = 2;
        for (int k = 1; k >= 0; k--) if (mg[k] < mg[imin]) imin = k;
        imed = 3 - imax - imin;
        fmaxi = 0;                                              // R4
        for (int k = 1; k < 3; k++) if (fr[k] > fr[fmaxi]) fmaxi = k;
        fmini = 2;
        for (int k = 1; k >= 0; k--) if (fr[k] < fr[fmini]) fmini = k;
        if (fmaxi == imax) begin exp_case = 0; off = ONE - fr[fmaxi]; end
        else if (fmini == imax) begin exp_case = 1; off = -fr[fmini]; end
        else if (fmaxi == imed) begin exp_case = 2; off = ONE - fr[fmaxi]; end
        else begin exp_case = 3; off = -fr[fmini]; end
        for (int k = 0; k < 3; k++) begin
            exp_mod[k] = rc[k] + off;                           // R8
            if (exp_mod[k] < 0) exp_mod[k] = 0;
            if (exp_mod[k] > TOP) exp_mod[k] = TOP;
        end
    endtask

    task automatic apply(input int ra, input int rb, input int rcv,
                         input int ca, input int cb, input int cc, input string tag);
        string t;
        @(negedge clk);
        ref_a = 16'(ra); ref_b = 16'(rb); ref_c = 16'(rcv);
        cur_a = 16'(ca); cur_b = 16'(cb); cur_c = 16'(cc);
        tr[0] = int'(ref_a); tr[1] = int'(ref_b); tr[2] = int'(ref_c);
        tc[0] = int'(cur_a); tc[1] = int'(cur_b); tc[2] = int'(cur_c);
        in_valid = 1'b1;
        model();
        @(negedge clk);
        in_valid = 1'b0;
        if (tag != "") t = tag;
        else if (exp_case == 0) t = "R5";
        else if (exp_case == 1) t = "R6";
        else t = "R7";
        chk(out_valid == 1'b1, "R9 valid", int'(out_valid), 1);
        chk(int'(case_code) == exp_case, {t, " case"}, int'(case_code), exp_case);
        chk(int'(mod_a) == exp_mod[0], {t, " R8 mod_a"}, int'(mod_a), exp_mod[0]);
        chk(int'(mod_b) == exp_mod[1], {t, " R8 mod_b"}, int'(mod_b), exp_mod[1]);
        chk(int'(mod_c) == exp_mod[2], {t, " R8 mod_c"}, int'(mod_c), exp_mod[2]);
    endtask

    task automatic hold_check();
        logic [15:0] pa, pb, pc;
        logic [1:0] pk;
        pa = mod_a; pb = mod_b; pc = mod_c; pk = case_code;
        ref_a = ~ref_a; ref_b = 16'h1234; cur_a = ~cur_a; cur_c = 16'sd5;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 idle valid", int'(out_valid), 0);
        chk(mod_a == pa && mod_b == pb && mod_c == pc, "R9 hold mods",
            int'(mod_a), int'(pa));
        chk(case_code == pk, "R9 hold case", int'(case_code), int'(pk));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        real th, m, pi;
        int ia, ib, ic, ca, cb, cc;
        void'($urandom(32'd20240611));
        pi = 3.14159265358979;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(out_valid == 1'b0, "R10 valid", int'(out_valid), 0);
        chk(mod_a == 0 && mod_b == 0 && mod_c == 0, "R10 mods", int'(mod_a), 0);
        chk(case_code == 2'd0, "R10 case", int'(case_code), 0);
        rst_n = 1'b1;

        // directed corners
        apply(16'hFFFF, 12000, 20000, 3000, 100, -200, "R1");
        apply(16'h9000, 16'h8001, 8192, 50, 60, 70, "R1");
        apply(TOP, 16384, 0, 900, -100, 50, "R2");
        apply(TOP, 8192, 4096, -50, 10, 900, "R2");
        apply(10000, 20000, 27000, 400, 400, 400, "R3");
        apply(10000, 20000, 27000, -32768, 32767, 0, "R3");
        apply(5000, 5000, 30000, 700, -700, 10, "R3");
        apply(9000, 17192, 25384, 10, 600, 300, "R4");
        apply(ONE, 2*ONE, 3*ONE, 100, 200, 300, "R4");
        hold_check();

        // sweep modulation index and angle with a lagging load current
        for (int mi = 1; mi <= 10; mi++) begin
            m = mi / 10.0;
            for (int s = 0; s < 36; s++) begin
                th = 2.0 * pi * s / 36.0;
                ia = int'((2.0 + 2.0 * m * $cos(th)) * ONE);
                ib = int'((2.0 + 2.0 * m * $cos(th - 2.0*pi/3.0)) * ONE);
                ic = int'((2.0 + 2.0 * m * $cos(th + 2.0*pi/3.0)) * ONE);
                ca = int'(20000.0 * m * $cos(th - 0.5));
                cb = int'(20000.0 * m * $cos(th - 0.5 - 2.0*pi/3.0));
                cc = int'(20000.0 * m * $cos(th - 0.5 + 2.0*pi/3.0));
                apply(ia, ib, ic, ca, cb, cc, "");
            end
        end

        // random samples, some over range
        for (int n = 0; n < 300; n++) begin
            ia = int'($urandom_range(0, 36000));
            ib = int'($urandom_range(0, 32768));
            ic = int'($urandom_range(0, 32768));
            ca = int'($signed(16'($urandom)));
            cb = int'($signed(16'($urandom)));
            cc = (n % 7 == 0) ? ca : int'($signed(16'($urandom)));
            apply(ia, ib, ic, ca, cb, cc, "");
            if (n % 50 == 0) hold_check();
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule